// File: doc/BRIEF.md
# Wait-State Transfer Acknowledge Generator

This block terminates bus cycles that land in the catch-all memory region, which is all address space not claimed by any other decoder. A 16-bit configuration word sets a wait-state count and two auto-acknowledge enables. The first enable covers cycles started by the on-chip processor and the second covers cycles started by an external bus master. The word also carries burst, port-size and address-hold fields, which are stored and read back for use by neighbouring logic.

Each bus cycle begins with a one-clock start strobe and a flag that says which kind of master owns the cycle. There are three ways a cycle can end:

- **Processor cycle, auto-acknowledge on:** the block raises its done pulse once the programmed number of wait states has passed. An external acknowledge that arrives earlier cuts the count short.
- **Processor cycle, auto-acknowledge off:** the block waits for the external acknowledge, whatever the count.
- **External-master cycle, auto-acknowledge on:** the block enables its acknowledge driver and asserts the acknowledge when the count expires.

When every region access is acknowledged automatically, accesses to addresses with no memory behind them still complete normally.

Top module: `dflt_ack_gen`

## Requirements
- R1: After reset the configuration reads 0x0000, `cyc_done` is low and `ack_oe` is low.
- R2: A write stores bits 13..10 (wait count), 9 (burst), 8 (core auto-ack), 7..6 (port size), 5 (external-master auto-ack), 3 and 2 (write/read hold). Bits 15, 14, 4, 1 and 0 always read zero. `cfg_rd_data` shows the stored word in the cycle after the write edge.
- R3: The start strobe is sampled high at clock edge k, and the cycle is a processor cycle with bit 8 set. Then `cyc_done` is high during the clock cycle that follows edge k+WS. With WS=0, that is the cycle right after the start edge.
- R4: In a processor cycle with bit 8 set, if `ext_ack_in` is high before the count expires, `cyc_done` is high in that same clock cycle and the cycle ends.
- R5: In a processor cycle with bit 8 clear, `cyc_done` is high only in a clock cycle where `ext_ack_in` is high, whatever WS is.
- R6: In an external-master cycle with bit 5 set, `ack_oe` is high from the cycle after the start edge through the done cycle. `ack_drive` and `cyc_done` are high together only at the R3 timing. `ext_ack_in` has no effect on this kind of cycle.
- R7: In an external-master cycle with bit 5 clear, `ack_oe` and `ack_drive` stay low, and `cyc_done` follows `ext_ack_in`.
- R8: Each cycle produces exactly one `cyc_done` pulse. After the pulse, `ext_ack_in` does nothing until the next start. A start strobe during an open cycle reloads the count and restarts the timing.
- R9: The master flag, both enables and WS are captured at the start edge. A configuration write during an open cycle does not change that cycle.
- R10: `ack_oe` is low throughout processor cycles, and `ack_drive` is never high while `ack_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | One-clock strobe that opens a bus cycle |
| cyc_ext_mstr | input | 1 | 1 = external master owns the cycle, 0 = processor; sampled with `cyc_start` |
| ext_ack_in | input | 1 | External transfer acknowledge, active high |
| cfg_wr_en | input | 1 | Configuration write enable |
| cfg_wr_data | input | 16 | Configuration write data |
| cfg_rd_data | output | 16 | Stored configuration word |
| cyc_done | output | 1 | Cycle-termination pulse |
| ack_drive | output | 1 | Acknowledge value to drive onto the bus |
| ack_oe | output | 1 | Output enable for the acknowledge driver |

## Verification
Every wait count from 0 to 15 is run under all four termination modes. This shows the counted path, the acknowledge-only path and the driven path each ending on their own timing.

For the processor auto mode, an external acknowledge is placed in three positions:

- before expiry, which separates early termination from counting;
- after expiry, which shows the acknowledge is ignored once the cycle has ended;
- not at all.

In driven-acknowledge runs, the external acknowledge is pulsed at cycle 0 to show it is ignored. Directed sequences restart a cycle in mid-count and rewrite the configuration inside an open cycle. Separate write patterns sweep the configuration word to expose the reserved bits.

// File: rtl/dflt_ack_pkg.sv
package dflt_ack_pkg;

  localparam int CFG_W     = 16;
  localparam int WS_W      = 4;
  localparam int WS_LSB    = 10;
  localparam int BURST_BIT = 9;
  localparam int CORE_BIT  = 8;
  localparam int PSZ_LSB   = 6;
  localparam int EXTM_BIT  = 5;
  localparam int WRH_BIT   = 3;
  localparam int RDH_BIT   = 2;

  // Writable bits: 13..5 and 3..2.
  localparam logic [CFG_W-1:0] CFG_WMASK =
      (((CFG_W)'(1) << (WS_LSB + WS_W)) - (CFG_W)'(1 << EXTM_BIT)) |
      (CFG_W)'(1 << WRH_BIT) | (CFG_W)'(1 << RDH_BIT);

  typedef enum logic [1:0] {
    TERM_COUNT = 2'd0,  // processor, count or early external ack
    TERM_WAIT  = 2'd1,  // external ack only
    TERM_DRIVE = 2'd2   // external master, block drives the ack
  } term_mode_t;

  function automatic term_mode_t pick_mode(input logic ext_mstr,
                                           input logic core_auto,
                                           input logic ext_auto);
    if (ext_mstr) return ext_auto ? TERM_DRIVE : TERM_WAIT;
    return core_auto ? TERM_COUNT : TERM_WAIT;
  endfunction

endpackage

// File: rtl/dack_cfg_reg.sv
module dack_cfg_reg
  import dflt_ack_pkg::*;
#(
  parameter int              W     = CFG_W,
  parameter logic [W-1:0]    WMASK = CFG_WMASK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] cfg_q
);

  logic [W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) cfg_d = wr_data & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cfg_q == ($past(wr_data) & WMASK)));

  assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/dack_wait_ctr.sv
module dack_wait_ctr #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          run,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load | run;
    cnt_d  = load ? load_val : (cnt_q - CW'(1));
    zero   = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_ctr_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  assert_ctr_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));

endmodule

// File: rtl/dack_seq.sv
module dack_seq
  import dflt_ack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_start,
  input  logic cyc_ext_mstr,
  input  logic core_auto,
  input  logic ext_auto,
  input  logic ext_ack_in,
  input  logic cnt_zero,
  output logic cnt_load,
  output logic cnt_run,
  output logic cyc_done,
  output logic ack_drive,
  output logic ack_oe
);

  logic       busy_q, busy_d;
  term_mode_t mode_q, mode_d;
  logic       term_hit;

  always_comb begin
    unique case (mode_q)
      TERM_COUNT: term_hit = cnt_zero | ext_ack_in;
      TERM_WAIT:  term_hit = ext_ack_in;
      TERM_DRIVE: term_hit = cnt_zero;
      default:    term_hit = 1'b0;
    endcase
    cyc_done  = busy_q & term_hit;
    ack_oe    = busy_q & (mode_q == TERM_DRIVE);
    ack_drive = ack_oe & cnt_zero;
    cnt_load  = cyc_start;
    cnt_run   = busy_q & ~cnt_zero;

    busy_d = busy_q;
    mode_d = mode_q;
    if (cyc_start) begin
      busy_d = 1'b1;
      mode_d = pick_mode(cyc_ext_mstr, core_auto, ext_auto);
    end else if (cyc_done) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mode_q <= TERM_COUNT;
    end else begin
      busy_q <= busy_d;
      if (cyc_start) mode_q <= mode_d;
    end
  end

  assert_single_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && !cyc_start) |=> !cyc_done);

  assert_wait_needs_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_done && mode_q == TERM_WAIT) |-> ext_ack_in);

  assert_drive_ends_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_drive |-> (cyc_done && cnt_zero));

  assert_core_no_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && !cyc_ext_mstr) |=> !ack_oe);

endmodule

// File: rtl/dflt_ack_gen.sv
module dflt_ack_gen
  import dflt_ack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             cyc_ext_mstr,
  input  logic             ext_ack_in,
  input  logic             cfg_wr_en,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic [CFG_W-1:0] cfg_rd_data,
  output logic             cyc_done,
  output logic             ack_drive,
  output logic             ack_oe
);

  // Reset asserts asynchronously and is released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic [CFG_W-1:0] cfg_q;
  logic             cnt_load, cnt_run, cnt_zero;

  dack_cfg_reg #(.W(CFG_W), .WMASK(CFG_WMASK)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .wr_en   (cfg_wr_en),
    .wr_data (cfg_wr_data),
    .cfg_q   (cfg_q)
  );

  dack_wait_ctr #(.CW(WS_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .load     (cnt_load),
    .load_val (cfg_q[WS_LSB +: WS_W]),
    .run      (cnt_run),
    .zero     (cnt_zero)
  );

  dack_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .cyc_start    (cyc_start),
    .cyc_ext_mstr (cyc_ext_mstr),
    .core_auto    (cfg_q[CORE_BIT]),
    .ext_auto     (cfg_q[EXTM_BIT]),
    .ext_ack_in   (ext_ack_in),
    .cnt_zero     (cnt_zero),
    .cnt_load     (cnt_load),
    .cnt_run      (cnt_run),
    .cyc_done     (cyc_done),
    .ack_drive    (ack_drive),
    .ack_oe       (ack_oe)
  );

  assign cfg_rd_data = cfg_q;

  assert_oe_covers_drive_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    ack_drive |-> ack_oe);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cfg_rd_data & ~CFG_WMASK) == '0);

endmodule

// File: tb/dflt_ack_gen_tb.sv
`timescale 1ns/1ps
module dflt_ack_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_start, cyc_ext_mstr, ext_ack_in, cfg_wr_en;
  logic [15:0] cfg_wr_data, cfg_rd_data;
  logic        cyc_done, ack_drive, ack_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dflt_ack_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_ext_mstr(cyc_ext_mstr),
    .ext_ack_in(ext_ack_in), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .cyc_done(cyc_done), .ack_drive(ack_drive),
    .ack_oe(ack_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Checks the outputs at the current negedge, after the inputs have settled.
  task automatic obs(input string req, input bit e_done, input bit e_oe, input bit e_drv);
    #1;
    chk(req, "cyc_done", {15'd0, cyc_done}, {15'd0, e_done});
    chk(req, "ack_oe", {15'd0, ack_oe}, {15'd0, e_oe});
    chk(req, "ack_drive", {15'd0, ack_drive}, {15'd0, e_drv});
  endtask

  task automatic wr_cfg(input logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  function automatic logic [15:0] mk_cfg(input int ws, input bit aa, input bit emaa);
    return (16'(ws) << 10) | (16'(aa) << 8) | (16'(emaa) << 5);
  endfunction

  // Opens one bus cycle and watches it for 20 clock cycles.
  // ack_at is the cycle index at which ext_ack_in is pulsed (-1 = never).
  task automatic run_case(input string req, input bit ext, input bit aa,
                          input bit emaa, input int ws, input int ack_at);
    int exp_idx;
    bit drv;
    wr_cfg(mk_cfg(ws, aa, emaa));
    drv = ext && emaa;
    if (!ext && aa) exp_idx = (ack_at >= 0 && ack_at < ws) ? ack_at : ws;
    else if (drv)   exp_idx = ws;
    else            exp_idx = ack_at;
    @(negedge clk);
    cyc_start = 1'b1; cyc_ext_mstr = ext;
    @(negedge clk);
    cyc_start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      ext_ack_in = (i == ack_at);
      obs(req, i == exp_idx, drv && i <= exp_idx, drv && i == exp_idx);
      @(negedge clk);
    end
    ext_ack_in = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cyc_start = 0; cyc_ext_mstr = 0; ext_ack_in = 0;
    cfg_wr_en = 0; cfg_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    #1;
    chk("R1", "cfg_rd_data", cfg_rd_data, 16'h0000);
    chk("R1", "cyc_done", {15'd0, cyc_done}, 16'd0);
    chk("R1", "ack_oe", {15'd0, ack_oe}, 16'd0);

    // R2: register write patterns, reserved bits read zero
    begin
      logic [15:0] pats [6] = '{16'hFFFF, 16'hAAAA, 16'h5555, 16'hC013, 16'h3FEC, 16'h0000};
      foreach (pats[p]) begin
        wr_cfg(pats[p]);
        #1 chk("R2", "cfg_rd_data", cfg_rd_data, pats[p] & 16'h3FEC);
      end
      for (int b = 0; b < 16; b++) begin
        wr_cfg(16'(1) << b);
        #1 chk("R2", "walking bit", cfg_rd_data, (16'(1) << b) & 16'h3FEC);
      end
    end

    // Sweep every wait count under every termination mode.
    for (int ws = 0; ws < 16; ws++) begin
      run_case("R3", 1'b0, 1'b1, 1'b0, ws, -1);
      if (ws > 0) run_case("R4", 1'b0, 1'b1, 1'b0, ws, ws / 2);
      run_case("R8", 1'b0, 1'b1, 1'b0, ws, ws + 2);
      run_case("R5", 1'b0, 1'b0, 1'b1, ws, (ws * 3) % 17);
      run_case("R6", 1'b1, 1'b0, 1'b1, ws, 0);
      run_case("R7", 1'b1, 1'b1, 1'b0, ws, ws % 5);
      run_case("R10", 1'b0, 1'b1, 1'b1, ws, -1);
    end

    // R8: a start strobe in mid-cycle reloads the count
    wr_cfg(mk_cfg(6, 1'b1, 1'b0));
    @(negedge clk); cyc_start = 1'b1; cyc_ext_mstr = 1'b0;
    @(negedge clk); cyc_start = 1'b0;
    obs("R8", 0, 0, 0);
    @(negedge clk);
    obs("R8", 0, 0, 0);
    @(negedge clk);
    cyc_start = 1'b1;
    obs("R8", 0, 0, 0);
    @(negedge clk); cyc_start = 1'b0;
    for (int j = 0; j < 10; j++) begin
      obs("R8", j == 6, 0, 0);
      @(negedge clk);
    end

    // R9: a configuration write inside an open cycle has no effect on it
    wr_cfg(mk_cfg(5, 1'b1, 1'b0));
    @(negedge clk); cyc_start = 1'b1; cyc_ext_mstr = 1'b0;
    @(negedge clk); cyc_start = 1'b0;
    obs("R9", 0, 0, 0);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = 16'h0000;
    obs("R9", 0, 0, 0);
    @(negedge clk);
    cfg_wr_en = 1'b0;
    for (int j = 2; j < 9; j++) begin
      obs("R9", j == 5, 0, 0);
      @(negedge clk);
    end
    #1 chk("R9", "cfg_rd_data", cfg_rd_data, 16'h0000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule